// File: doc/BRIEF.md
# Clock-Status Flag Register with Interrupt Gating

This block is the 8-bit status and flag register of a clock, reset and power management unit. It holds three kinds of bits in one byte. Sticky event flags record a periodic timer timeout and the cause of the last reset (power-on, low-voltage, illegal address). Live read-only bits show the PLL lock state and whether the oscillator is qualified. Change flags latch any toggle of those two live bits. Sticky and change flags are cleared by writing a one to their position. Writing a zero leaves them alone.

A small write/read port also reaches an interrupt-enable byte and a post-divider value. The block gates three interrupt requests with their enable bits. It also drives the PLL output-divider select. While the PLL is unlocked, the select is forced to a safe divide-by-four; once lock is reached, it takes the programmed value. The lock and oscillator inputs are asynchronous, so they pass through a synchronizer before edge detection. The stop-mode inputs force the oscillator-qualified bit low under the conditions listed below.

There are two resets. `por_n` is an asynchronous power-on reset that initialises everything. `sys_rst` is a synchronous system reset. It clears all state except the reset-cause flags, so software can read why the chip restarted.

Top module: `cpm_status_reg`

## Requirements
- R1: The status byte at read address 0 has this layout: bit 7 timer flag, bit 6 power-on flag, bit 5 low-voltage flag, bit 4 lock-change flag, bit 3 lock status, bit 2 illegal-address flag, bit 1 oscillator-change flag, bit 0 oscillator-qualified status. Address 1 reads the enable byte, which keeps only bit 7 (timer), bit 4 (lock change) and bit 1 (oscillator change); its other bits read 0. Address 2 reads the post-divider in its low POSTDIV_W bits. Address 3 reads 0.
- R2: After power-on reset, the status byte reads 0x40 with both raw status inputs low. The enable byte and post-divider read 0, no interrupt is requested, and the divider select is 3.
- R3: Writing to address 0 clears each flag (bits 7, 6, 5, 4, 2, 1) whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: Writes to address 0 never change the lock status (bit 3) or the oscillator-qualified status (bit 0).
- R5: A one-cycle pulse on `rti_tick`, `lvr_evt` or `ila_evt` sets bit 7, bit 5 or bit 2 respectively.
- R6: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R7: The lock status follows `lock_raw` through a SYNC_STAGES-flop synchronizer. With the default of 2 stages, it reads 1 after the second rising edge, not the first. The lock-change flag sets on every change of the synchronized lock status, in either direction.
- R8: The oscillator-qualified status is a register. It loads 1 only when the synchronized `osc_raw` is 1, `full_stop` is 0, and the synchronized lock is 1 or `pseudo_stop` is 1; otherwise it loads 0. The oscillator-change flag sets whenever this status changes.
- R9: `rti_irq`, `lock_irq` and `osc_irq` are each the AND of status bits 7, 4 and 1 with enable bits 7, 4 and 1 respectively.
- R10: `div_sel` is 3 while the lock status is 0. While the lock status is 1, it equals the programmed post-divider.
- R11: `sys_rst` clears the timer, lock-change and oscillator-change flags, the enable byte and the post-divider. It leaves the power-on, low-voltage and illegal-address flags untouched, and it takes priority over writes and the timer event.
- R12: A later power-on reset sets the power-on flag and clears the low-voltage and illegal-address flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 status, 1 enables, 2 post-divider |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| rti_tick | input | 1 | Timer period-end pulse |
| lvr_evt | input | 1 | Low-voltage reset event pulse |
| ila_evt | input | 1 | Illegal-address reset event pulse |
| lock_raw | input | 1 | Asynchronous PLL lock indication |
| osc_raw | input | 1 | Asynchronous oscillator-qualified indication |
| full_stop | input | 1 | Full stop mode entry |
| pseudo_stop | input | 1 | Pseudo stop mode entry |
| rti_irq | output | 1 | Timer interrupt request |
| lock_irq | output | 1 | Lock-change interrupt request |
| osc_irq | output | 1 | Oscillator-change interrupt request |
| div_sel | output | POSTDIV_W | PLL output divider select (f = fVCO/(div_sel+1)) |

## Verification
The bench builds the block with SYNC_STAGES at 2 and POSTDIV_W at 3. This makes the two-edge lock latency an exact cycle check. The narrow divider means random writes cover every divider code and exercise the truncation of the upper data bits, including the code 3 that matches the unlocked select. Directed sequences walk the lock and oscillator inputs through full stop, pseudo stop and lock loss. A random phase mixes writes, events and system resets against a bench model of the flag rules.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    // Bit positions inside the status byte (decoded by software)
    localparam int FLG_TMR   = 7;
    localparam int FLG_POR   = 6;
    localparam int FLG_LVR   = 5;
    localparam int FLG_LCHG  = 4;
    localparam int FLG_LOCK  = 3;
    localparam int FLG_ILA   = 2;
    localparam int FLG_OCHG  = 1;
    localparam int FLG_OSCQ  = 0;

    localparam logic [7:0] W1C_MASK   = 8'hF6; // flags cleared by writing 1
    localparam logic [7:0] CAUSE_MASK = 8'h64; // reset-cause flags
    localparam logic [7:0] IEN_MASK   = 8'h92; // implemented enable bits
    localparam logic [7:0] POR_FLAGS  = 8'h40; // status after power-on

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_IEN  = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam int UNLOCK_DIV = 3; // fVCO/4 while unlocked

    typedef struct packed {
        logic lock_prev;
        logic oscq;
    } core_st_t;

endpackage

// File: rtl/cpm_sync.sv
module cpm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef logic [WIDTH-1:0] row_t;

    row_t [STAGES-1:0] chain_d;
    row_t [STAGES-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign chain_d[s] = din;
        end else begin : g_next
            assign chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cpm_status_core.sv
module cpm_status_core
    import cpm_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic lock_s,
    input  logic osc_s,
    input  logic full_stop,
    input  logic pseudo_stop,
    output logic lock_o,
    output logic oscq_o,
    output logic lock_chg_o,
    output logic osc_chg_o
);
    core_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.lock_prev = lock_s;
        st_d.oscq      = osc_s && !full_stop && (lock_s || pseudo_stop);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o     = lock_s;
    assign oscq_o     = st_q.oscq;
    assign lock_chg_o = lock_s ^ st_q.lock_prev;
    assign osc_chg_o  = st_d.oscq ^ st_q.oscq;

    // R8
    full_stop_drops_osc_chk: assert property (@(posedge clk) disable iff (!por_n)
        full_stop |=> !oscq_o);

    // R8
    lock_loss_drops_osc_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!lock_o && !pseudo_stop) |=> !oscq_o);

endmodule

// File: rtl/cpm_flag_bank.sv
module cpm_flag_bank
    import cpm_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst,
    input  logic [7:0] set_i,
    input  logic [7:0] clr_i,
    output logic [7:0] flags_o
);
    logic [7:0] flags_d, flags_q;
    logic       unused_live_clr;

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < 8; i++) begin
            if (!W1C_MASK[i]) begin
                flags_d[i] = 1'b0;
            end else if (sys_rst && !CAUSE_MASK[i]) begin
                flags_d[i] = 1'b0;
            end else if (set_i[i]) begin
                flags_d[i] = 1'b1;
            end else if (clr_i[i]) begin
                flags_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flags_q <= POR_FLAGS;
        else        flags_q <= flags_d;
    end

    assign flags_o         = (flags_q & W1C_MASK) | (set_i & ~W1C_MASK);
    assign unused_live_clr = ^(clr_i & ~W1C_MASK);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && set_i[FLG_TMR]) |=> flags_q[FLG_TMR]);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && ((set_i | clr_i) & W1C_MASK) == 8'h00) |=> $stable(flags_q));

    // R11
    cause_survives_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && (clr_i & CAUSE_MASK) == 8'h00)
        |=> ((flags_q & $past(flags_q) & CAUSE_MASK) == ($past(flags_q) & CAUSE_MASK)));

    // R11
    sysrst_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (flags_q & W1C_MASK & ~CAUSE_MASK) == 8'h00);

endmodule

// File: rtl/cpm_status_reg.sv
module cpm_status_reg
    import cpm_pkg::*;
#(
    parameter int POSTDIV_W   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sys_rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [1:0]           rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 rti_tick,
    input  logic                 lvr_evt,
    input  logic                 ila_evt,
    input  logic                 lock_raw,
    input  logic                 osc_raw,
    input  logic                 full_stop,
    input  logic                 pseudo_stop,
    output logic                 rti_irq,
    output logic                 lock_irq,
    output logic                 osc_irq,
    output logic [POSTDIV_W-1:0] div_sel
);
    localparam logic [POSTDIV_W-1:0] SAFE_DIV = POSTDIV_W'(UNLOCK_DIV);

    typedef struct packed {
        logic [7:0]           ien;
        logic [POSTDIV_W-1:0] pdiv;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic [1:0] raw_pair, sync_pair;
    logic       lock_s, osc_s;
    logic       lock_st, oscq_st, lock_chg, osc_chg;
    logic [7:0] set_vec, clr_vec, flags;

    assign raw_pair = {lock_raw, osc_raw};

    cpm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (raw_pair),
        .dout  (sync_pair)
    );

    assign lock_s = sync_pair[1];
    assign osc_s  = sync_pair[0];

    cpm_status_core u_core (
        .clk         (clk),
        .por_n       (por_n),
        .lock_s      (lock_s),
        .osc_s       (osc_s),
        .full_stop   (full_stop),
        .pseudo_stop (pseudo_stop),
        .lock_o      (lock_st),
        .oscq_o      (oscq_st),
        .lock_chg_o  (lock_chg),
        .osc_chg_o   (osc_chg)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_TMR]  = rti_tick;
        set_vec[FLG_LVR]  = lvr_evt;
        set_vec[FLG_LCHG] = lock_chg;
        set_vec[FLG_LOCK] = lock_st;
        set_vec[FLG_ILA]  = ila_evt;
        set_vec[FLG_OCHG] = osc_chg;
        set_vec[FLG_OSCQ] = oscq_st;
        clr_vec = (wr_en && wr_addr == ADDR_STAT) ? wr_data : 8'h00;
    end

    cpm_flag_bank u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (sys_rst) begin
            ctl_d = '0;
        end else if (wr_en && wr_addr == ADDR_IEN) begin
            ctl_d.ien = wr_data & IEN_MASK;
        end else if (wr_en && wr_addr == ADDR_DIV) begin
            ctl_d.pdiv = wr_data[POSTDIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_STAT: rd_data = flags;
            ADDR_IEN:  rd_data = ctl_q.ien;
            ADDR_DIV:  rd_data = 8'(ctl_q.pdiv);
            default:   rd_data = 8'h00;
        endcase
    end

    assign rti_irq  = flags[FLG_TMR]  & ctl_q.ien[FLG_TMR];
    assign lock_irq = flags[FLG_LCHG] & ctl_q.ien[FLG_LCHG];
    assign osc_irq  = flags[FLG_OCHG] & ctl_q.ien[FLG_OCHG];
    assign div_sel  = lock_st ? ctl_q.pdiv : SAFE_DIV;

    // R7
    lock_toggle_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && lock_st != $past(lock_st)) |=> flags[FLG_LCHG]);

    // R8
    osc_toggle_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && osc_chg) |=> flags[FLG_OCHG]);

    // R10
    unlocked_div_chk: assert property (@(posedge clk) disable iff (!por_n)
        !flags[FLG_LOCK] |-> div_sel == SAFE_DIV);

endmodule

// File: tb/cpm_status_reg_bench.sv
module cpm_status_reg_bench;
    localparam int CLK_P = 10;
    localparam int PD_W  = 3;
    localparam int SYNC  = 2;

    logic            clk = 0;
    logic            por_n = 0, sys_rst = 0, wr_en = 0;
    logic [1:0]      wr_addr = 0, rd_addr = 0;
    logic [7:0]      wr_data = 0, rd_data;
    logic            rti_tick = 0, lvr_evt = 0, ila_evt = 0;
    logic            lock_raw = 0, osc_raw = 0, full_stop = 0, pseudo_stop = 0;
    logic            rti_irq, lock_irq, osc_irq;
    logic [PD_W-1:0] div_sel;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cpm_status_reg #(.POSTDIV_W(PD_W), .SYNC_STAGES(SYNC)) u_cpm_status_reg (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rti_tick(rti_tick), .lvr_evt(lvr_evt), .ila_evt(ila_evt),
        .lock_raw(lock_raw), .osc_raw(osc_raw), .full_stop(full_stop),
        .pseudo_stop(pseudo_stop), .rti_irq(rti_irq), .lock_irq(lock_irq),
        .osc_irq(osc_irq), .div_sel(div_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    function automatic logic [7:0] rd(input logic [1:0] a);
        rd_addr = a;
        return 8'h00;
    endfunction

    task automatic rchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // Bench model of the flag rules (R3, R5, R6, R11)
    function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] s,
                                              input logic [7:0] c, input logic srst);
        logic [7:0] n = f;
        for (int i = 0; i < 8; i++) begin
            if (8'hF6 & (8'h1 << i)) begin
                if (srst && !(8'h64 & (8'h1 << i))) n[i] = 1'b0;
                else if (s[i])                      n[i] = 1'b1;
                else if (c[i])                      n[i] = 1'b0;
            end
        end
        return n;
    endfunction

    initial begin
        #(CLK_P * 60000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] m_flags, m_ien;
        logic [PD_W-1:0] m_pd;
        void'($urandom(32'h5EED_C0DE));
        void'(rd(0));
        tick(3);
        por_n = 1;
        tick();
        // R2
        rchk("R2 status after por", 0, 8'h40);
        rchk("R2 enables after por", 1, 8'h00);
        rchk("R2 postdiv after por", 2, 8'h00);
        chk("R2 irqs", {rti_irq, lock_irq, osc_irq}, 0);
        chk("R10 unlocked div", div_sel, 3);
        rchk("R1 addr3 reads 0", 3, 8'h00);
        // R3
        wr(0, 8'h00);
        rchk("R3 zero write keeps por flag", 0, 8'h40);
        wr(0, 8'h40);
        rchk("R3 one write clears por flag", 0, 8'h00);
        // R5 / R1 / R9 / R6
        rti_tick = 1; tick(); rti_tick = 0;
        rchk("R5 timer flag", 0, 8'h80);
        wr(1, 8'hFF);
        rchk("R1 enable mask", 1, 8'h92);
        chk("R9 timer irq", rti_irq, 1);
        rti_tick = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h80; tick(); wr_en = 0; rti_tick = 0;
        rchk("R6 set beats clear", 0, 8'h80);
        wr(0, 8'h80);
        rchk("R3 timer cleared", 0, 8'h00);
        chk("R9 timer irq off", rti_irq, 0);
        // R7 lock latency and change flag
        wr(2, 8'hFD);
        rchk("R1 postdiv truncation", 2, 8'h05);
        lock_raw = 1;
        tick();
        rchk("R7 lock not after one edge", 0, 8'h00);
        tick();
        chk("R7 lock after two edges", rd_data[3], 1);
        tick(3);
        rchk("R7 lock and change flag", 0, 8'h18);
        chk("R9 lock irq", lock_irq, 1);
        chk("R10 locked div", div_sel, 5);
        wr(0, 8'h09);
        rchk("R4 live bits ignore writes", 0, 8'h18);
        wr(0, 8'h10);
        rchk("R3 clear lock change", 0, 8'h08);
        // R8 oscillator
        osc_raw = 1;
        tick(5);
        rchk("R8 osc qualified", 0, 8'h0B);
        chk("R9 osc irq", osc_irq, 1);
        wr(0, 8'h02);
        rchk("R8 osc change cleared", 0, 8'h09);
        full_stop = 1; tick(); full_stop = 0;
        rchk("R8 full stop drops osc", 0, 8'h0A);
        tick();
        rchk("R8 osc back after stop", 0, 8'h0B);
        wr(0, 8'h02);
        pseudo_stop = 1; lock_raw = 0;
        tick(5);
        rchk("R8 pseudo stop keeps osc", 0, 8'h11);
        chk("R10 div forced on lock loss", div_sel, 3);
        pseudo_stop = 0;
        tick();
        rchk("R8 lock loss drops osc", 0, 8'h12);
        lock_raw = 1;
        tick(5);
        rchk("R7 relock", 0, 8'h1B);
        wr(0, 8'h12);
        rchk("R3 clear both change flags", 0, 8'h09);
        // R11
        rti_tick = 1; lvr_evt = 1; ila_evt = 1; tick();
        rti_tick = 0; lvr_evt = 0; ila_evt = 0;
        rchk("R5 all events", 0, 8'hAD);
        sys_rst = 1; tick(); sys_rst = 0;
        rchk("R11 cause flags survive", 0, 8'h2D);
        rchk("R11 enables cleared", 1, 8'h00);
        rchk("R11 postdiv cleared", 2, 8'h00);
        chk("R11 div after sys reset", div_sel, 0);
        // R12
        por_n = 0; tick(); por_n = 1; tick();
        rchk("R12 por resets cause flags", 0, 8'h40);
        tick(6);
        rchk("R12 relock after por", 0, 8'h5B);
        wr(0, 8'h12);
        // Random phase, lock and oscillator held high
        m_flags = 8'h49; m_ien = 0; m_pd = 0;
        rchk("R1 random start", 0, m_flags);
        for (int n = 0; n < 400; n++) begin
            logic [7:0] s, c;
            wr_en    = ($urandom % 3) == 0;
            wr_addr  = 2'($urandom);
            wr_data  = 8'($urandom);
            rti_tick = ($urandom % 5) == 0;
            lvr_evt  = ($urandom % 9) == 0;
            ila_evt  = ($urandom % 9) == 0;
            sys_rst  = ($urandom % 23) == 0;
            s = {rti_tick, 1'b0, lvr_evt, 2'b00, ila_evt, 2'b00};
            c = (wr_en && wr_addr == 0) ? wr_data : 8'h00;
            m_flags = next_flags(m_flags, s, c, sys_rst);
            if (sys_rst) begin
                m_ien = 0; m_pd = 0;
            end else if (wr_en && wr_addr == 1) begin
                m_ien = wr_data & 8'h92;
            end else if (wr_en && wr_addr == 2) begin
                m_pd = wr_data[PD_W-1:0];
            end
            tick();
            wr_en = 0; rti_tick = 0; lvr_evt = 0; ila_evt = 0; sys_rst = 0;
            rchk("R3 random status", 0, m_flags);
            rchk("R1 random enables", 1, m_ien);
            rchk("R1 random postdiv", 2, 8'(m_pd));
            chk("R9 random irqs", {rti_irq, lock_irq, osc_irq},
                {m_flags[7] & m_ien[7], m_flags[4] & m_ien[4], m_flags[1] & m_ien[1]});
            chk("R10 random div", div_sel, m_pd);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule